// File: doc/BRIEF.md
# Multi-lane link alignment unit

This block removes the skew between four receive lanes of a serial link. The lanes have already been decoded to bytes. Each lane brings an 8-bit byte, a flag that marks the byte as a control character, and a lock indication. Periodically every lane carries an alignment character: data byte 0x7C with the control flag set. The block measures when that character arrives on each lane. It then delays each lane through a 16-entry ring buffer so that the alignment characters of a group leave the block on the same cycle.

Static configuration inputs set the grouping and the trigger. Lanes can be aligned as two independent pairs or as one group of four. Alignment can wait for one to four complete measurement rounds, and it can be gated on several lock conditions. A manual override replaces the measured delays with fixed per-lane values. An optional dynamic mode keeps measuring after alignment, applies new delays when the arrival pattern changes, and raises a sticky error when it sees the alignment characters leave a group out of step.

Top module: `lane_deskew`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `tx_data`, `tx_ctrl`, `grp_aligned` and `align_err` are all zero.
- R2: While `cfg_en` is 0, no delay is added. Each lane output equals its input one clock later, and `grp_aligned` stays 0.
- R3: An alignment character is data 0x7C together with a control flag of 1. In automatic mode, each lane's delay is the arrival time of the latest alignment character in its group minus the arrival time of its own. With input skews s_l, every output lane of the group then equals the common source delayed by max(s_l) cycles.
- R4: `cfg_trig` = k sets the number of complete rounds needed for alignment to k+1. A round is one alignment character seen on every lane of the group. `grp_aligned` stays 0 until that round completes.
- R5: `cfg_quad` = 1 aligns lanes 0 to 3 as one group, and both bits of `grp_aligned` show that group. `cfg_quad` = 0 aligns lanes {1,0} as group 0 (bit 0) and lanes {3,2} as group 1 (bit 1), each independently.
- R6: `cfg_start` gates measurement. 000 needs every lane of the group locked. 001 needs any lane of the group locked. 010, 011, 100 and 101 need lane 0, 1, 2 or 3 locked. 110 and 111 never start.
- R7: When the lock condition fails, `grp_aligned` clears on the next cycle and the round count starts again from zero.
- R8: With `cfg_force` = 1 and `cfg_en` = 1, lane l is delayed by `cfg_man_dly[4l+3:4l]` cycles, whatever was measured.
- R9: With `cfg_dyn` = 0, the delays and `grp_aligned` stay frozen once alignment is reached, even if the skew later changes, and `align_err` stays 0.
- R10: With `cfg_dyn` = 1, measurement continues after alignment, and new delays are loaded whenever a round gives a different arrival pattern.
- R11: With `cfg_dyn` = 1 and a group aligned, `align_err` is set if that group's outputs show an alignment character on some lanes but not all of them. It then stays set until reset.
- R12: A round is discarded if the group's alignment characters are spread over more than 16 cycles (offset above 15). A spread of exactly 15 still aligns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 32 | Lane input bytes, lane l at bits [8l+7:8l] |
| rx_ctrl | input | 4 | Per-lane control-character flag |
| rx_lock | input | 4 | Per-lane lock indication |
| cfg_en | input | 1 | Alignment enable |
| cfg_quad | input | 1 | 1 = one group of four lanes, 0 = two pairs |
| cfg_trig | input | 2 | Rounds needed, minus one |
| cfg_start | input | 3 | Lock condition code |
| cfg_force | input | 1 | Use manual delays |
| cfg_dyn | input | 1 | Keep monitoring and realigning |
| cfg_man_dly | input | 16 | Manual delays, lane l at bits [4l+3:4l] |
| tx_data | output | 32 | Deskewed lane bytes |
| tx_ctrl | output | 4 | Deskewed control flags |
| grp_aligned | output | 2 | Per-group aligned flag |
| align_err | output | 1 | Sticky misalignment flag |

## Verification
The bench uses the default parameters: four lanes, 8-bit bytes and a 16-entry lane buffer. It places an alignment character every 40 cycles, so skews from 0 to 15 cycles can be drawn at random, and one directed case uses a spread of 20 to exceed the window. A single source stream with per-lane offsets means every expected output is simply that source delayed by a known amount. The same setup drives the drift cases, where one lane's skew is changed between alignment characters.

// File: rtl/lane_deskew_pkg.sv
package lane_deskew_pkg;

  // Lock-condition codes for cfg_start; lane-specific codes follow GATE_LANE0 in lane order.
  typedef enum logic [2:0] {
    GATE_ALL   = 3'd0,
    GATE_ANY   = 3'd1,
    GATE_LANE0 = 3'd2
  } gate_e;

  localparam int TRIG_W = 2;
  localparam int GATE_W = 3;

endpackage

// File: rtl/lane_deskew_buf.sv
module lane_deskew_buf #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] in_d,
  input  logic          in_c,
  input  logic [PW-1:0] dly,
  output logic [DW-1:0] out_d,
  output logic          out_c
);

  // Ring buffer: entry written dly cycles ago sits at wr_ptr - dly.
  logic [DW:0]   mem [DEPTH];
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] rd_ptr;

  assign rd_ptr = wr_ptr - dly;

  always_ff @(posedge clk) begin
    mem[wr_ptr] <= {in_c, in_d};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      out_d  <= '0;
      out_c  <= 1'b0;
    end else begin
      wr_ptr <= wr_ptr + 1'b1;
      if (dly == '0) begin
        {out_c, out_d} <= {in_c, in_d};
      end else begin
        {out_c, out_d} <= mem[rd_ptr];
      end
    end
  end

endmodule

// File: rtl/lane_deskew_grp.sv
module lane_deskew_grp #(
  parameter int LANES = 4,
  parameter int PW    = 4,
  parameter int TW    = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      run,
  input  logic                      gate,
  input  logic                      dyn,
  input  logic [LANES-1:0]          mask,
  input  logic [LANES-1:0]          hit_in,
  input  logic [TW-1:0]             trig,
  output logic [LANES-1:0][PW-1:0]  dly_o,
  output logic                      aligned_o
);

  localparam logic [PW-1:0] CMAX = '1;

  logic                     win_open;
  logic [PW-1:0]            cnt;
  logic [PW-1:0]            cur;
  logic [PW-1:0]            latest;
  logic [LANES-1:0]         seen;
  logic [LANES-1:0]         seen_e;
  logic [LANES-1:0]         fresh;
  logic [LANES-1:0]         seen_n;
  logic [LANES-1:0][PW-1:0] off;
  logic [LANES-1:0][PW-1:0] off_n;
  logic [LANES-1:0][PW-1:0] meas;
  logic [TW:0]              rounds;
  logic                     done;
  logic                     measuring;

  always_comb begin
    seen_e = win_open ? seen : '0;
    cur    = win_open ? cnt : '0;
    fresh  = hit_in & mask & ~seen_e;
    seen_n = seen_e | fresh;
    done   = (seen_n != '0) && ((seen_n & mask) == mask);
    latest = '0;
    for (int k = 0; k < LANES; k++) begin
      off_n[k] = fresh[k] ? cur : off[k];
      if (mask[k] && (off_n[k] > latest)) latest = off_n[k];
    end
    for (int k = 0; k < LANES; k++) begin
      meas[k] = mask[k] ? (latest - off_n[k]) : '0;
    end
    measuring = run && gate && (!aligned_o || dyn);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_open  <= 1'b0;
      cnt       <= '0;
      seen      <= '0;
      off       <= '0;
      rounds    <= '0;
      dly_o     <= '0;
      aligned_o <= 1'b0;
    end else if (!run || !gate) begin
      win_open  <= 1'b0;
      seen      <= '0;
      rounds    <= '0;
      aligned_o <= 1'b0;
    end else if (measuring) begin
      if (done) begin
        win_open <= 1'b0;
        seen     <= '0;
        off      <= off_n;
        if (!aligned_o) begin
          if (rounds >= {1'b0, trig}) begin
            dly_o     <= meas;
            aligned_o <= 1'b1;
            rounds    <= '0;
          end else begin
            rounds <= rounds + 1'b1;
          end
        end else begin
          dly_o <= meas;
        end
      end else if (seen_n != '0) begin
        if (win_open && (cnt == CMAX)) begin
          win_open <= 1'b0;
          seen     <= '0;
        end else begin
          win_open <= 1'b1;
          cnt      <= cur + 1'b1;
          seen     <= seen_n;
          off      <= off_n;
        end
      end
    end
  end

endmodule

// File: rtl/lane_deskew.sv
module lane_deskew
  import lane_deskew_pkg::*;
#(
  parameter int            LANES      = 4,
  parameter int            DW         = 8,
  parameter int            DEPTH      = 16,
  parameter logic [DW-1:0] ALIGN_CODE = 'h7C,
  localparam int           PW         = $clog2(DEPTH),
  localparam int           NGRP       = LANES / 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [LANES*DW-1:0]   rx_data,
  input  logic [LANES-1:0]      rx_ctrl,
  input  logic [LANES-1:0]      rx_lock,
  input  logic                  cfg_en,
  input  logic                  cfg_quad,
  input  logic [TRIG_W-1:0]     cfg_trig,
  input  logic [GATE_W-1:0]     cfg_start,
  input  logic                  cfg_force,
  input  logic                  cfg_dyn,
  input  logic [LANES*PW-1:0]   cfg_man_dly,
  output logic [LANES*DW-1:0]   tx_data,
  output logic [LANES-1:0]      tx_ctrl,
  output logic [NGRP-1:0]       grp_aligned,
  output logic                  align_err
);

  function automatic logic gate_met(input logic [GATE_W-1:0] sel,
                                    input logic [LANES-1:0]  lk,
                                    input logic [LANES-1:0]  m);
    logic r;
    r = 1'b0;
    case (sel)
      GATE_ALL: r = (m != '0) && ((lk & m) == m);
      GATE_ANY: r = |(lk & m);
      default: begin
        for (int k = 0; k < LANES; k++) begin
          if (int'(sel) == int'(GATE_LANE0) + k) r = lk[k];
        end
      end
    endcase
    return r;
  endfunction

  logic [LANES-1:0]         hit_in;
  logic [LANES-1:0]         out_hit;
  logic [PW-1:0]            dly_sel [LANES];
  logic [LANES-1:0][PW-1:0] gdly    [NGRP];
  logic [LANES-1:0]         gmask   [NGRP];
  logic [NGRP-1:0]          galigned;
  logic [NGRP-1:0]          aligned_q;
  logic [NGRP-1:0]          gbad;

  // Measurement and delay control per group
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic grun;
    logic ggate;

    assign gmask[g] = cfg_quad ? ((g == 0) ? {LANES{1'b1}} : {LANES{1'b0}})
                               : (LANES'(2'b11) << (2 * g));
    assign grun  = cfg_en && (gmask[g] != '0);
    assign ggate = gate_met(cfg_start, rx_lock, gmask[g]);

    lane_deskew_grp #(
      .LANES (LANES),
      .PW    (PW),
      .TW    (TRIG_W)
    ) u_grp (
      .clk       (clk),
      .rst       (rst),
      .run       (grun),
      .gate      (ggate),
      .dyn       (cfg_dyn),
      .mask      (gmask[g]),
      .hit_in    (hit_in),
      .trig      (cfg_trig),
      .dly_o     (gdly[g]),
      .aligned_o (galigned[g])
    );

    // Output monitor starts one cycle after alignment so the delay switch settles
    always_ff @(posedge clk) begin
      if (rst) aligned_q[g] <= 1'b0;
      else     aligned_q[g] <= galigned[g];
    end

    assign gbad[g] = aligned_q[g] && cfg_dyn && (|(out_hit & gmask[g])) &&
                     ((out_hit & gmask[g]) != gmask[g]);
  end

  // Lane datapath
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int PG = l / 2;

    assign hit_in[l] = rx_ctrl[l] && (rx_data[l*DW +: DW] == ALIGN_CODE);

    always_comb begin
      if (!cfg_en)       dly_sel[l] = '0;
      else if (cfg_force) dly_sel[l] = cfg_man_dly[l*PW +: PW];
      else if (cfg_quad)  dly_sel[l] = gdly[0][l];
      else                dly_sel[l] = gdly[PG][l];
    end

    lane_deskew_buf #(
      .DW    (DW),
      .DEPTH (DEPTH),
      .PW    (PW)
    ) u_buf (
      .clk   (clk),
      .rst   (rst),
      .in_d  (rx_data[l*DW +: DW]),
      .in_c  (rx_ctrl[l]),
      .dly   (dly_sel[l]),
      .out_d (tx_data[l*DW +: DW]),
      .out_c (tx_ctrl[l])
    );

    assign out_hit[l] = tx_ctrl[l] && (tx_data[l*DW +: DW] == ALIGN_CODE);
  end

  always_ff @(posedge clk) begin
    if (rst)        align_err <= 1'b0;
    else if (|gbad) align_err <= 1'b1;
  end

  assign grp_aligned = cfg_quad ? {NGRP{galigned[0]}} : galigned;

endmodule

// File: rtl/lane_deskew_chk.sv
module lane_deskew_chk #(
  parameter int LANES = 4,
  parameter int DW    = 8,
  parameter int NGRP  = 2
) (
  input logic                clk,
  input logic                rst,
  input logic [LANES*DW-1:0] rx_data,
  input logic [LANES-1:0]    rx_lock,
  input logic                cfg_en,
  input logic                cfg_quad,
  input logic [2:0]          cfg_start,
  input logic                cfg_dyn,
  input logic [LANES*DW-1:0] tx_data,
  input logic [NGRP-1:0]     grp_aligned,
  input logic                align_err
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (grp_aligned == '0) && !align_err && (tx_data == '0));

  // R2
  bypass_data_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> tx_data == $past(rx_data));

  // R2
  bypass_flag_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> grp_aligned == '0);

  // R7
  lock_loss_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && cfg_quad && (cfg_start == 3'd0) && !(&rx_lock)) |=> grp_aligned == '0);

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    align_err |=> align_err);

  // R11
  err_needs_dyn_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(align_err) |-> $past(cfg_dyn));

endmodule

bind lane_deskew lane_deskew_chk #(
  .LANES (LANES),
  .DW    (DW),
  .NGRP  (NGRP)
) u_chk (.*);

// File: tb/lane_deskew_bench.sv
module lane_deskew_bench;
  localparam int LANES = 4;
  localparam int DW    = 8;
  localparam int DEPTH = 16;
  localparam int PW    = 4;
  localparam int NGRP  = 2;

  logic                clk = 1'b0;
  logic                rst;
  logic [LANES*DW-1:0] rx_data;
  logic [LANES-1:0]    rx_ctrl;
  logic [LANES-1:0]    rx_lock;
  logic                cfg_en, cfg_quad, cfg_force, cfg_dyn;
  logic [1:0]          cfg_trig;
  logic [2:0]          cfg_start;
  logic [LANES*PW-1:0] cfg_man_dly;
  logic [LANES*DW-1:0] tx_data;
  logic [LANES-1:0]    tx_ctrl;
  logic [NGRP-1:0]     grp_aligned;
  logic                align_err;

  always #5 clk = ~clk;

  lane_deskew #(.LANES(LANES), .DW(DW), .DEPTH(DEPTH)) u_lane_deskew (
    .clk(clk), .rst(rst), .rx_data(rx_data), .rx_ctrl(rx_ctrl), .rx_lock(rx_lock),
    .cfg_en(cfg_en), .cfg_quad(cfg_quad), .cfg_trig(cfg_trig), .cfg_start(cfg_start),
    .cfg_force(cfg_force), .cfg_dyn(cfg_dyn), .cfg_man_dly(cfg_man_dly),
    .tx_data(tx_data), .tx_ctrl(tx_ctrl), .grp_aligned(grp_aligned), .align_err(align_err)
  );

  int         ecount = 0;
  logic [DW:0] hist [64];
  int         skew [LANES];
  int         dexp [LANES];
  int         man  [LANES];
  int         checks = 0;
  int         errors = 0;

  always @(posedge clk) ecount <= ecount + 1;

  // Source byte for edge t: alignment character every 40 edges, random data otherwise
  function automatic logic [DW:0] src(int t);
    if (t < 0) return '0;
    return hist[t % 64];
  endfunction

  function automatic int maxof(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic tick();
    @(negedge clk);
    hist[ecount % 64] = ((ecount % 40) == 0) ? {1'b1, 8'h7C} : {1'b0, 8'($urandom)};
    for (int l = 0; l < LANES; l++) begin
      {rx_ctrl[l], rx_data[l*DW +: DW]} = src(ecount - skew[l]);
    end
  endtask

  task automatic wait_until(int e);
    while (ecount - 1 < e) tick();
  endtask

  task automatic wait_phase(int ph);
    do tick(); while ((ecount % 40) != ph);
  endtask

  task automatic check_val(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_data(string req, int n);
    int bad = 0;
    int fl = 0;
    logic [DW:0] fa = '0;
    logic [DW:0] fe = '0;
    for (int i = 0; i < n; i++) begin
      tick();
      for (int l = 0; l < LANES; l++) begin
        logic [DW:0] act;
        logic [DW:0] exp;
        act = {tx_ctrl[l], tx_data[l*DW +: DW]};
        exp = src(ecount - 1 - dexp[l]);
        if (act !== exp) begin
          if (bad == 0) begin fa = act; fe = exp; fl = l; end
          bad++;
        end
      end
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s lane %0d data: got %h expected %h (%0d mismatches)", req, fl, fa, fe, bad);
    end
  endtask

  task automatic relock(logic [LANES-1:0] lk);
    rx_lock = '0;
    repeat (4) tick();
    wait_phase(20);
    rx_lock = lk;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int tl;
    int n;
    int mx;
    void'($urandom(32'd2024));
    for (int i = 0; i < 64; i++) hist[i] = '0;
    for (int l = 0; l < LANES; l++) begin skew[l] = 0; dexp[l] = 0; man[l] = 0; end
    rst = 1'b1; rx_data = '0; rx_ctrl = '0; rx_lock = '0;
    cfg_en = 1'b0; cfg_quad = 1'b1; cfg_trig = 2'd0; cfg_start = 3'd0;
    cfg_force = 1'b0; cfg_dyn = 1'b0; cfg_man_dly = '0;
    repeat (5) tick();
    // R1 reset state
    check_val("R1", "tx_data", int'(tx_data != '0), 0);
    check_val("R1", "tx_ctrl", int'(tx_ctrl), 0);
    check_val("R1", "grp_aligned", int'(grp_aligned), 0);
    check_val("R1", "align_err", int'(align_err), 0);
    rst = 1'b0;

    // R2 disabled: pass through with no added delay
    for (int l = 0; l < LANES; l++) skew[l] = $urandom % 16;
    rx_lock = '1;
    repeat (30) tick();
    for (int l = 0; l < LANES; l++) dexp[l] = skew[l];
    check_data("R2", 60);
    check_val("R2", "grp_aligned", int'(grp_aligned), 0);

    // R3/R4 random skews and trigger counts, four-lane group
    cfg_en = 1'b1; cfg_quad = 1'b1; cfg_start = 3'd0;
    for (int it = 0; it < 4; it++) begin
      cfg_trig = (it == 0) ? 2'd3 : 2'($urandom % 4);
      for (int l = 0; l < LANES; l++) skew[l] = $urandom % 16;
      relock('1);
      tl = ecount;
      n = int'(cfg_trig) + 1;
      wait_until(tl + 20 + 40 * (n - 1) - 5);
      check_val("R4", "aligned before last round", int'(grp_aligned), 0);
      wait_until(tl + 20 + 40 * (n - 1) + 25);
      check_val("R4", "aligned after last round", int'(grp_aligned), 3);
      mx = 0;
      for (int l = 0; l < LANES; l++) mx = maxof(mx, skew[l]);
      for (int l = 0; l < LANES; l++) dexp[l] = mx;
      check_data("R3", 80);
    end

    // R7 lock loss clears flag and restarts the round count
    cfg_trig = 2'd1;
    rx_lock = 4'b1110;
    repeat (2) tick();
    check_val("R7", "aligned after lock loss", int'(grp_aligned), 0);
    relock('1);
    tl = ecount;
    wait_until(tl + 55);
    check_val("R7", "aligned after one round", int'(grp_aligned), 0);
    wait_until(tl + 85);
    check_val("R7", "aligned after two rounds", int'(grp_aligned), 3);

    // R5 pairs aligned independently
    cfg_quad = 1'b0; cfg_trig = 2'd0;
    for (int l = 0; l < LANES; l++) skew[l] = $urandom % 16;
    relock('1);
    repeat (100) tick();
    check_val("R5", "pair flags", int'(grp_aligned), 3);
    dexp[0] = maxof(skew[0], skew[1]); dexp[1] = dexp[0];
    dexp[2] = maxof(skew[2], skew[3]); dexp[3] = dexp[2];
    check_data("R5", 80);
    relock(4'b0011);
    repeat (150) tick();
    check_val("R5", "only pair 0 locked", int'(grp_aligned), 1);

    // R6 start conditions, four-lane group
    cfg_quad = 1'b1;
    cfg_start = 3'd0; relock(4'b0111); repeat (150) tick();
    check_val("R6", "all-lanes code, one unlocked", int'(grp_aligned), 0);
    cfg_start = 3'd1; relock(4'b0100); repeat (150) tick();
    check_val("R6", "any-lane code", int'(grp_aligned), 3);
    cfg_start = 3'd2; relock(4'b0001); repeat (150) tick();
    check_val("R6", "lane0 code", int'(grp_aligned), 3);
    cfg_start = 3'd5; relock(4'b0111); repeat (150) tick();
    check_val("R6", "lane3 code, lane3 unlocked", int'(grp_aligned), 0);
    relock(4'b1000); repeat (150) tick();
    check_val("R6", "lane3 code, lane3 locked", int'(grp_aligned), 3);
    cfg_start = 3'd7; relock('1); repeat (150) tick();
    check_val("R6", "unused code", int'(grp_aligned), 0);

    // R12 spread beyond the window
    cfg_start = 3'd0;
    skew[0] = 0; skew[1] = 0; skew[2] = 0; skew[3] = 20;
    relock('1); repeat (200) tick();
    check_val("R12", "spread 20", int'(grp_aligned), 0);
    skew[3] = 15;
    relock('1); repeat (100) tick();
    check_val("R12", "spread 15", int'(grp_aligned), 3);
    for (int l = 0; l < LANES; l++) dexp[l] = 15;
    check_data("R12", 80);

    // R8 manual delays
    cfg_force = 1'b1;
    for (int l = 0; l < LANES; l++) begin
      man[l]  = 1 + ($urandom % 15);
      skew[l] = $urandom % 16;
      cfg_man_dly[l*PW +: PW] = PW'(man[l]);
      dexp[l] = man[l] + skew[l];
    end
    repeat (40) tick();
    check_data("R8", 80);
    cfg_force = 1'b0;

    // R9 frozen delays without dynamic mode
    cfg_dyn = 1'b0;
    skew[0] = 3; skew[1] = 8; skew[2] = 1; skew[3] = 6;
    relock('1); repeat (100) tick();
    check_val("R9", "aligned", int'(grp_aligned), 3);
    wait_phase(30);
    skew[2] = 4;
    repeat (100) tick();
    dexp[0] = 8; dexp[1] = 8; dexp[2] = 11; dexp[3] = 8;
    check_data("R9", 80);
    check_val("R9", "align_err", int'(align_err), 0);

    // R10/R11 dynamic realignment and sticky error
    cfg_dyn = 1'b1;
    skew[2] = 1;
    relock('1); repeat (120) tick();
    check_val("R11", "no error while steady", int'(align_err), 0);
    wait_phase(30);
    skew[2] = 12;
    repeat (150) tick();
    check_val("R11", "error after drift", int'(align_err), 1);
    check_val("R10", "still aligned", int'(grp_aligned), 3);
    for (int l = 0; l < LANES; l++) dexp[l] = 12;
    check_data("R10", 80);
    relock('1); repeat (100) tick();
    check_val("R11", "error sticky", int'(align_err), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule